// File: doc/BRIEF.md
# Registered Integer ALU with Immediate Extension

This unit is the execute-stage arithmetic and logic core of a three-operand load/store integer pipeline. Each cycle it takes a register operand A, a second operand that is either register operand B or a 16-bit immediate, a 5-bit shift distance and a 4-bit operation code. One clock edge later it presents a 32-bit result and a flag that marks an all-zero result.

The unit extends the immediate according to the operation. Arithmetic and compare operations sign-extend it. Bitwise operations zero-extend it. The upper-constant operation places it in the high half of the word. Shifts always act on operand A by the shift distance input. Add and subtract wrap silently. Decode, multiply/divide and overflow traps are handled elsewhere in the pipeline.

Top module: `risc_alu`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next outputs are `result_o`=0 and `zero_o`=1. Otherwise the outputs show the operation on the inputs sampled at the previous rising edge, one cycle of latency.
- R2: Code 0x0 (add) returns A+B and code 0x1 (subtract) returns A-B, both modulo 2^32, with no overflow indication.
- R3: Code 0x2 returns A AND B, code 0x3 returns A OR B, and code 0x4 returns NOT(A OR B), each bit by bit.
- R4: When `imm_sel_i` is 1 and the code is 0x2, 0x3 or 0x4, the second operand is the immediate with bits 31:16 forced to zero.
- R5: When `imm_sel_i` is 1 and the code is 0x0, 0x1, 0x5 or 0x6, the second operand is the immediate with bit 15 copied into bits 31:16.
- R6: Code 0x5 returns 1 when A < B as two's complement numbers and 0 otherwise. A=0xFFFFFFFA, B=0x0000FFFA gives 1.
- R7: Code 0x6 returns 1 when A < B as unsigned magnitudes and 0 otherwise. A=0xFFFFFFFA, B=0x0000FFFA gives 0.
- R8: Code 0x7 shifts A left and code 0x8 shifts A right, each by `shamt_i` (0 to 31), filling vacated bits with zeros.
- R9: Code 0x9 shifts A right by `shamt_i` and fills vacated bits with copies of A bit 31.
- R10: Code 0xA returns the immediate in bits 31:16 and zeros in bits 15:0. A, B and `imm_sel_i` have no effect on this result.
- R11: `zero_o` is 1 exactly when `result_o` is 0.
- R12: Codes 0xB to 0xF return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | Register operand A |
| b_i | input | 32 | Register operand B |
| imm_i | input | 16 | Immediate field |
| imm_sel_i | input | 1 | 1 selects the extended immediate as second operand |
| shamt_i | input | 5 | Shift distance |
| result_o | output | 32 | Registered result |
| zero_o | output | 1 | Registered all-zero flag |

## Verification
The embedded properties check on every cycle that the zero flag agrees with the result. They also check that both compare codes produce only 0 or 1, that the upper-constant result has a clear low half, that the arithmetic right shift of a negative operand keeps bit 31 set, that unused codes give zero, and that reset clears the output. Only the directed scenarios can show that the arithmetic is correct. These cover wrap-around at 2^32, the signed versus unsigned ordering of the same operand pair, and which extension applies to each immediate form. They also cover exact shift fill at distances 0, 8 and 31, and the upper-constant result ignoring register operand A.

// File: rtl/risc_alu_pkg.sv
// Shared definitions for the integer ALU: operation codes and widths.
// Assumes a 4-bit operation code. Codes above OP_LUI are unused.
package risc_alu_pkg;
    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] OP_ADD  = 4'h0;
    localparam logic [OP_W-1:0] OP_SUB  = 4'h1;
    localparam logic [OP_W-1:0] OP_AND  = 4'h2;
    localparam logic [OP_W-1:0] OP_OR   = 4'h3;
    localparam logic [OP_W-1:0] OP_NOR  = 4'h4;
    localparam logic [OP_W-1:0] OP_SLT  = 4'h5;
    localparam logic [OP_W-1:0] OP_SLTU = 4'h6;
    localparam logic [OP_W-1:0] OP_SLL  = 4'h7;
    localparam logic [OP_W-1:0] OP_SRL  = 4'h8;
    localparam logic [OP_W-1:0] OP_SRA  = 4'h9;
    localparam logic [OP_W-1:0] OP_LUI  = 4'hA;

    // True for operations whose immediate is sign-extended.
    function automatic logic imm_is_signed(input logic [OP_W-1:0] op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_SLT) || (op == OP_SLTU);
    endfunction
endpackage

// File: rtl/risc_alu_opnd.sv
// Second-operand select: register B or the extended immediate.
// Sign extension for arithmetic and compare codes, zero extension otherwise.
// Assumes DATA_W > IMM_W.
module risc_alu_opnd
    import risc_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              imm_sel_i,
    output logic [DATA_W-1:0] opnd_o
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;

    // Extend the immediate with its sign bit or with zeros.
    always_comb begin
        if (imm_is_signed(op_i))
            imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
        else
            imm_ext = {{EXT_W{1'b0}}, imm_i};
    end

    // Pick the second operand.
    assign opnd_o = imm_sel_i ? imm_ext : b_i;
endmodule

// File: rtl/risc_alu_shift.sv
// Logarithmic barrel shifter. Left shifts reuse the right-shift stages on a
// bit-reversed word. Arithmetic fill applies only to right shifts.
// Assumes SH_W = clog2(W) with W a power of two.
module risc_alu_shift #(
    parameter int W    = 32,
    parameter int SH_W = $clog2(W)
) (
    input  logic [W-1:0]    val_i,
    input  logic [SH_W-1:0] amt_i,
    input  logic            left_i,
    input  logic            arith_i,
    output logic [W-1:0]    res_o
);
    logic [W-1:0] stg [0:SH_W];
    logic [W-1:0] pre;
    logic         fill;

    // Fill bit for vacated positions.
    assign fill = arith_i & ~left_i & val_i[W-1];

    for (genvar i = 0; i < W; i++) begin : g_rev_in
        // Reverse the input for left shifts.
        assign pre[i] = left_i ? val_i[W-1-i] : val_i[i];
    end

    assign stg[0] = pre;

    for (genvar s = 0; s < SH_W; s++) begin : g_stage
        localparam int DIST = 1 << s;
        // Shift right by 2^s when the matching distance bit is set.
        assign stg[s+1] = amt_i[s] ? {{DIST{fill}}, stg[s][W-1:DIST]} : stg[s];
    end

    for (genvar i = 0; i < W; i++) begin : g_rev_out
        // Undo the reversal for left shifts.
        assign res_o[i] = left_i ? stg[SH_W][W-1-i] : stg[SH_W][i];
    end
endmodule

// File: rtl/risc_alu_cmp.sv
// Less-than comparator giving signed and unsigned results from one
// subtractor borrow. Assumes W >= 2.
module risc_alu_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         lt_s_o,
    output logic         lt_u_o
);
    logic [W:0] diff;

    // Widened subtraction. The top bit is the unsigned borrow.
    assign diff   = {1'b0, a_i} - {1'b0, b_i};
    assign lt_u_o = diff[W];
    // On differing signs the negative operand is smaller.
    assign lt_s_o = (a_i[W-1] ^ b_i[W-1]) ? a_i[W-1] : lt_u_o;
endmodule

// File: rtl/risc_alu.sv
// Registered integer ALU: add, subtract, bitwise logic, signed and unsigned
// less-than, three shifts and upper-constant load, with an all-zero flag.
// One cycle of latency. Synchronous active-low reset. Unused codes give 0.
module risc_alu
    import risc_alu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IMM_W   = 16,
    parameter int SHAMT_W = $clog2(DATA_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OP_W-1:0]    op_i,
    input  logic [DATA_W-1:0]  a_i,
    input  logic [DATA_W-1:0]  b_i,
    input  logic [IMM_W-1:0]   imm_i,
    input  logic               imm_sel_i,
    input  logic [SHAMT_W-1:0] shamt_i,
    output logic [DATA_W-1:0]  result_o,
    output logic               zero_o
);
    localparam int LOW_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] sh_res;
    logic              lt_s, lt_u;
    logic              sh_left, sh_arith;
    logic [DATA_W-1:0] res_d;

    risc_alu_opnd #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
        .op_i      (op_i),
        .b_i       (b_i),
        .imm_i     (imm_i),
        .imm_sel_i (imm_sel_i),
        .opnd_o    (opnd_b)
    );

    risc_alu_cmp #(.W(DATA_W)) u_cmp (
        .a_i    (a_i),
        .b_i    (opnd_b),
        .lt_s_o (lt_s),
        .lt_u_o (lt_u)
    );

    // Shift direction and fill mode from the operation code.
    assign sh_left  = (op_i == OP_SLL);
    assign sh_arith = (op_i == OP_SRA);

    risc_alu_shift #(.W(DATA_W), .SH_W(SHAMT_W)) u_shift (
        .val_i   (a_i),
        .amt_i   (shamt_i),
        .left_i  (sh_left),
        .arith_i (sh_arith),
        .res_o   (sh_res)
    );

    // Select the result for the current code.
    always_comb begin
        case (op_i)
            OP_ADD:  res_d = a_i + opnd_b;
            OP_SUB:  res_d = a_i - opnd_b;
            OP_AND:  res_d = a_i & opnd_b;
            OP_OR:   res_d = a_i | opnd_b;
            OP_NOR:  res_d = ~(a_i | opnd_b);
            OP_SLT:  res_d = {{(DATA_W-1){1'b0}}, lt_s};
            OP_SLTU: res_d = {{(DATA_W-1){1'b0}}, lt_u};
            OP_SLL,
            OP_SRL,
            OP_SRA:  res_d = sh_res;
            OP_LUI:  res_d = {imm_i, {LOW_W{1'b0}}};
            default: res_d = '0;
        endcase
    end

    // Output register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            zero_o   <= 1'b1;
        end else begin
            result_o <= res_d;
            zero_o   <= (res_d == '0);
        end
    end

    // Marks that the previous edge loaded real inputs.
    logic past_ok;
    always_ff @(posedge clk) begin
        past_ok <= rst_n;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (result_o == '0 && zero_o));

    // R11
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (zero_o == (result_o == '0)));

    // R6 R7
    cmp_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && ($past(op_i) == OP_SLT || $past(op_i) == OP_SLTU))
        |-> (result_o[DATA_W-1:1] == '0));

    // R10
    lui_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(op_i) == OP_LUI)
        |-> (result_o[LOW_W-1:0] == '0 && result_o[DATA_W-1:LOW_W] == $past(imm_i)));

    // R9
    sra_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(op_i) == OP_SRA && $past(a_i[DATA_W-1]))
        |-> result_o[DATA_W-1]);

    // R12
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(op_i) > OP_LUI) |-> (result_o == '0));
endmodule

// File: tb/test_risc_alu.sv
// Directed bench for risc_alu: one task per scenario, each checking its results.
module test_risc_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op = '0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [15:0] imm = '0;
    logic        imm_sel = 1'b0;
    logic [4:0]  shamt = '0;
    logic [31:0] result;
    logic        zero;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    risc_alu i_risc_alu (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op),
        .a_i       (a),
        .b_i       (b),
        .imm_i     (imm),
        .imm_sel_i (imm_sel),
        .shamt_i   (shamt),
        .result_o  (result),
        .zero_o    (zero)
    );

    task automatic check(input string req, input logic [31:0] exp);
        checks++;
        if (result !== exp) begin
            errors++;
            $display("FAIL %s result: actual %08h expected %08h", req, result, exp);
        end
        checks++;
        if (zero !== (exp == 32'h0)) begin
            errors++;
            $display("FAIL R11 zero (%s): actual %0b expected %0b", req, zero, (exp == 32'h0));
        end
    endtask

    // Drive one operation at a falling edge and check it one falling edge later.
    task automatic run(input string req, input logic [3:0] o, input logic [31:0] va,
                       input logic [31:0] vb, input logic [15:0] vi, input logic vs,
                       input logic [4:0] vsh, input logic [31:0] exp);
        @(negedge clk);
        op = o; a = va; b = vb; imm = vi; imm_sel = vs; shamt = vsh;
        @(negedge clk);
        check(req, exp);
    endtask

    task automatic t_reset();
        @(negedge clk);
        op = 4'h0; a = 32'h1; b = 32'h1;
        @(negedge clk);
        check("R1 reset", 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_arith();
        run("R2 add wrap", 4'h0, 32'hFFFFFFFF, 32'h2, 16'h0, 1'b0, 5'd0, 32'h1);
        run("R2 sub neg", 4'h1, 32'h5, 32'h7, 16'h0, 1'b0, 5'd0, 32'hFFFFFFFE);
        run("R2 sub equal", 4'h1, 32'h1234, 32'h1234, 16'h0, 1'b0, 5'd0, 32'h0);
    endtask

    task automatic t_logic();
        run("R3 and", 4'h2, 32'hF0F0F0F0, 32'hFF00FF00, 16'h0, 1'b0, 5'd0, 32'hF000F000);
        run("R3 or", 4'h3, 32'hF0F0F0F0, 32'hFF00FF00, 16'h0, 1'b0, 5'd0, 32'hFFF0FFF0);
        run("R3 nor", 4'h4, 32'hF0F0F0F0, 32'hFF00FF00, 16'h0, 1'b0, 5'd0, 32'h000F000F);
    endtask

    task automatic t_imm_zero();
        run("R4 and imm", 4'h2, 32'hFFFFFFFF, 32'h0, 16'h8001, 1'b1, 5'd0, 32'h00008001);
        run("R4 or imm", 4'h3, 32'h12345678, 32'h0, 16'hFFFF, 1'b1, 5'd0, 32'h1234FFFF);
        run("R4 nor imm", 4'h4, 32'h0, 32'h0, 16'h8000, 1'b1, 5'd0, 32'hFFFF7FFF);
    endtask

    task automatic t_imm_sign();
        run("R5 add imm neg", 4'h0, 32'd10, 32'h0, 16'hFFCE, 1'b1, 5'd0, 32'hFFFFFFD8);
        run("R5 slt imm", 4'h5, 32'hFFFFFFF0, 32'h0, 16'h0001, 1'b1, 5'd0, 32'h1);
        run("R5 sltu imm", 4'h6, 32'h00010000, 32'h0, 16'hFFFF, 1'b1, 5'd0, 32'h1);
    endtask

    task automatic t_compare();
        run("R6 slt signed", 4'h5, 32'hFFFFFFFA, 32'h0000FFFA, 16'h0, 1'b0, 5'd0, 32'h1);
        run("R6 slt equal", 4'h5, 32'h7, 32'h7, 16'h0, 1'b0, 5'd0, 32'h0);
        run("R7 sltu", 4'h6, 32'hFFFFFFFA, 32'h0000FFFA, 16'h0, 1'b0, 5'd0, 32'h0);
        run("R7 sltu less", 4'h6, 32'h3, 32'h80000000, 16'h0, 1'b0, 5'd0, 32'h1);
    endtask

    task automatic t_shift();
        run("R8 sll 8", 4'h7, 32'h12345678, 32'h0, 16'h0, 1'b0, 5'd8, 32'h34567800);
        run("R8 srl 8", 4'h8, 32'h92345678, 32'h0, 16'h0, 1'b0, 5'd8, 32'h00923456);
        run("R8 sll 31", 4'h7, 32'h00000003, 32'h0, 16'h0, 1'b0, 5'd31, 32'h80000000);
        run("R8 srl 31", 4'h8, 32'h80000000, 32'h0, 16'h0, 1'b0, 5'd31, 32'h1);
        run("R8 sll 0", 4'h7, 32'hA5A5A5A5, 32'h0, 16'h0, 1'b0, 5'd0, 32'hA5A5A5A5);
        run("R9 sra neg", 4'h9, 32'h92345678, 32'h0, 16'h0, 1'b0, 5'd8, 32'hFF923456);
        run("R9 sra pos", 4'h9, 32'h12345678, 32'h0, 16'h0, 1'b0, 5'd8, 32'h00123456);
        run("R9 sra 31", 4'h9, 32'h80000000, 32'h0, 16'h0, 1'b0, 5'd31, 32'hFFFFFFFF);
    endtask

    task automatic t_upper();
        run("R10 lui", 4'hA, 32'hDEADBEEF, 32'h0, 16'hABCD, 1'b1, 5'd0, 32'hABCD0000);
        run("R10 lui reg sel", 4'hA, 32'h0000FFFF, 32'h12345678, 16'h0001, 1'b0, 5'd0, 32'h00010000);
    endtask

    task automatic t_unused();
        run("R12 code B", 4'hB, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hFFFF, 1'b0, 5'd3, 32'h0);
        run("R12 code F", 4'hF, 32'h12345678, 32'h1, 16'h1234, 1'b1, 5'd1, 32'h0);
    endtask

    initial begin
        t_reset();
        t_arith();
        t_logic();
        t_imm_zero();
        t_imm_sign();
        t_compare();
        t_shift();
        t_upper();
        t_unused();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule